// File: doc/BRIEF.md
# Partitioned Lane Add/Subtract and Logic Unit

This block is a 36-bit arithmetic and logic unit that can split its operands into independent lanes. A two-bit lane mode treats the operands as one 36-bit word, as two 18-bit halves or as four 9-bit quarters. In every mode the unit performs add, subtract, AND, OR and XOR. For add and subtract, no carry or borrow ever crosses from one lane into the next. One wide operation therefore gives the same result as a set of separate narrow operations, one per lane.

The arithmetic is combinational. A registered stage captures the result, and it is loaded only when the valid strobe is high. Each lane reports its own carry-out in a four-bit vector, and a valid strobe marks the cycle in which a new result appears. Internally, a control module decodes the opcode and lane mode into a small bundle of strobes. It also marks which 9-bit segments start and end a lane. The datapath module chains four 9-bit segment adders and cuts the chain wherever a lane starts.

Top module: `lane_alu`

## Requirements
- R1: While rstN is low, and after it is released, result, carryOut and validOut read zero until the first accepted operation.
- R2: With laneMode 2'b00 the operands form one 36-bit lane. Add gives (A+B) mod 2^36, and carryOut[0] holds bit 36 of the full sum.
- R3: With laneMode 2'b01, lane k (k=0,1) occupies bits 18k+17:18k. Each lane is computed on its own, and its carry goes to carryOut[k].
- R4: With laneMode 2'b10, lane k (k=0..3) occupies bits 9k+8:9k. Each lane is computed on its own, and its carry goes to carryOut[k].
- R5: laneMode 2'b11 behaves exactly like 2'b00.
- R6: Subtract (opcode 3'd1) computes A + ~B + 1 in every active lane. The lane carry is 1 exactly when that lane's A is greater than or equal to its B, so no borrow occurred.
- R7: Opcodes 3'd2 (AND), 3'd3 (OR) and 3'd4 (XOR) act bitwise across all 36 bits in every mode, and they drive carryOut to zero. Add is opcode 3'd0. Opcodes 3'd5 to 3'd7 give a zero result and a zero carry vector.
- R8: carryOut bits for lanes that do not exist in the current mode read zero.
- R9: When validIn is high at a clock edge, result and carryOut update at that edge and validOut is high for the following cycle. When validIn is low, result and carryOut hold and validOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Accept operands this cycle |
| opIn | input | 3 | Operation select |
| laneMode | input | 2 | Lane partition select |
| aIn | input | 36 | First operand |
| bIn | input | 36 | Second operand |
| result | output | 36 | Registered result |
| carryOut | output | 4 | Registered per-lane carry, lane k in bit k |
| validOut | output | 1 | High for the cycle after an accepted operation |

## Verification
A lane-start mark that is wrong inside the unit lets a carry leak across a lane boundary. This shows as an off-by-one in the low bit of the next lane, in the same result that carries the operation, one cycle after validIn. The operand patterns are chosen so that every boundary produces a carry, which makes such a leak visible at the ports. A wrong lane-end mapping shows up in that same cycle as a carry bit in the wrong position of carryOut, or as a nonzero bit for an unused lane. A wrong capture enable shows up as a result that changes while validIn is low.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam int SEG_W = 9;
  localparam int SEG_N = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } opCode_e;

  typedef enum logic [1:0] {
    LOGIC_AND  = 2'd0,
    LOGIC_OR   = 2'd1,
    LOGIC_XOR  = 2'd2,
    LOGIC_ZERO = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic             capture;
    logic             isSub;
    logic             arith;
    logicSel_e        logicSel;
    logic [SEG_N-1:0] laneStart;
    logic [SEG_N-1:0] laneEnd;
  } ctrlStrobes_t;
endpackage

// File: rtl/lane_alu_ctrl.sv
module lane_alu_ctrl
  import lane_alu_pkg::*;
#(
  parameter int SegN = SEG_N
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic [2:0]   opIn,
  input  logic [1:0]   laneMode,
  output ctrlStrobes_t ctrl,
  output logic         validOut
);
  localparam int HalfSegs    = SegN / 2;
  localparam int QuarterSegs = SegN / 4;

  int segsPerLane;

  always_comb begin
    case (laneMode)
      2'b01:   segsPerLane = HalfSegs;
      2'b10:   segsPerLane = QuarterSegs;
      default: segsPerLane = SegN;
    endcase
  end

  for (genvar s = 0; s < SegN; s++) begin : g_mark
    assign ctrl.laneStart[s] = ((s % segsPerLane) == 0);
    assign ctrl.laneEnd[s]   = (((s + 1) % segsPerLane) == 0);
  end

  always_comb begin
    ctrl.capture  = validIn;
    ctrl.isSub    = (opIn == OP_SUB);
    ctrl.arith    = (opIn == OP_ADD) || (opIn == OP_SUB);
    case (opIn)
      OP_AND:  ctrl.logicSel = LOGIC_AND;
      OP_OR:   ctrl.logicSel = LOGIC_OR;
      OP_XOR:  ctrl.logicSel = LOGIC_XOR;
      default: ctrl.logicSel = LOGIC_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  // R9: the output strobe follows the input strobe by exactly one cycle
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  p_valid_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
endmodule

// File: rtl/lane_alu_dp.sv
module lane_alu_dp
  import lane_alu_pkg::*;
#(
  parameter int SegW = SEG_W,
  parameter int SegN = SEG_N
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         ctrl,
  input  logic [SegW*SegN-1:0] aIn,
  input  logic [SegW*SegN-1:0] bIn,
  output logic [SegW*SegN-1:0] result,
  output logic [SegN-1:0]      carryOut
);
  localparam int DataW = SegW * SegN;
  localparam int IdxW  = $clog2(SegN);

  logic [DataW-1:0] sumBus;
  logic [DataW-1:0] logicBus;
  logic [SegN-1:0]  segCarry;
  logic [SegN-1:0]  segCin;

  for (genvar s = 0; s < SegN; s++) begin : g_seg
    logic [SegW-1:0] aSeg, bSeg;
    logic [SegW:0]   segSum;
    assign aSeg = aIn[s*SegW +: SegW];
    assign bSeg = bIn[s*SegW +: SegW] ^ {SegW{ctrl.isSub}};
    if (s == 0) begin : g_first
      assign segCin[s] = ctrl.isSub;
    end else begin : g_rest
      assign segCin[s] = ctrl.laneStart[s] ? ctrl.isSub : segCarry[s-1];
    end
    assign segSum = {1'b0, aSeg} + {1'b0, bSeg} + {{SegW{1'b0}}, segCin[s]};
    assign sumBus[s*SegW +: SegW] = segSum[SegW-1:0];
    assign segCarry[s] = segSum[SegW];
  end

  always_comb begin
    case (ctrl.logicSel)
      LOGIC_AND: logicBus = aIn & bIn;
      LOGIC_OR:  logicBus = aIn | bIn;
      LOGIC_XOR: logicBus = aIn ^ bIn;
      default:   logicBus = '0;
    endcase
  end

  logic [SegN-1:0] nextCarry;
  logic [IdxW:0]   laneIdx;

  always_comb begin
    nextCarry = '0;
    laneIdx   = '0;
    for (int s = 0; s < SegN; s++) begin
      if (ctrl.laneEnd[s]) begin
        nextCarry[laneIdx[IdxW-1:0]] = segCarry[s] & ctrl.arith;
        laneIdx = laneIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      carryOut <= '0;
    end else if (ctrl.capture) begin
      result   <= ctrl.arith ? sumBus : logicBus;
      carryOut <= nextCarry;
    end
  end

  // R9: with no capture the registered outputs keep their value
  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(result) && $stable(carryOut));
  // R3/R4: the first segment always opens a lane
  p_first_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.laneStart[0]);
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int SegW = SEG_W,
  parameter int SegN = SEG_N
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [2:0]           opIn,
  input  logic [1:0]           laneMode,
  input  logic [SegW*SegN-1:0] aIn,
  input  logic [SegW*SegN-1:0] bIn,
  output logic [SegW*SegN-1:0] result,
  output logic [SegN-1:0]      carryOut,
  output logic                 validOut
);
  ctrlStrobes_t ctrl;

  lane_alu_ctrl #(.SegN(SegN)) u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn),
    .laneMode(laneMode), .ctrl(ctrl), .validOut(validOut)
  );

  lane_alu_dp #(.SegW(SegW), .SegN(SegN)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .aIn(aIn), .bIn(bIn),
    .result(result), .carryOut(carryOut)
  );

  // R8: lanes that do not exist report no carry
  p_wide_unused_r8: assert property (@(posedge clk) disable iff (!rstN)
    validIn && (laneMode == 2'b00 || laneMode == 2'b11) |=> carryOut[SegN-1:1] == '0);
  p_half_unused_r8: assert property (@(posedge clk) disable iff (!rstN)
    validIn && laneMode == 2'b01 |=> carryOut[SegN-1:2] == '0);
  // R7: non-arithmetic opcodes never produce a carry
  p_logic_nocarry_r7: assert property (@(posedge clk) disable iff (!rstN)
    validIn && opIn >= 3'd2 |=> carryOut == '0);
  // R7: undefined opcodes give a zero result
  p_undef_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    validIn && opIn >= 3'd5 |=> result == '0);
endmodule

// File: tb/sim_lane_alu.sv
`timescale 1ns/1ps
module sim_lane_alu;
  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn;
  logic [2:0]  opIn;
  logic [1:0]  laneMode;
  logic [35:0] aIn, bIn;
  logic [35:0] result;
  logic [3:0]  carryOut;
  logic        validOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lane_alu u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn), .laneMode(laneMode),
    .aIn(aIn), .bIn(bIn), .result(result), .carryOut(carryOut), .validOut(validOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [35:0] a, input logic [35:0] b,
                                input logic [2:0] op, input logic [1:0] md,
                                output logic [35:0] res, output logic [3:0] cy);
    int w;
    int n;
    w = (md == 2'b01) ? 18 : (md == 2'b10) ? 9 : 36;
    n = 36 / w;
    res = '0;
    cy  = '0;
    case (op)
      3'd2: res = a & b;
      3'd3: res = a | b;
      3'd4: res = a ^ b;
      3'd0, 3'd1: begin
        for (int k = 0; k < n; k++) begin
          logic [63:0] mask, av, bv, s;
          mask = (64'd1 << w) - 1;
          av = ({28'd0, a} >> (k * w)) & mask;
          bv = ({28'd0, b} >> (k * w)) & mask;
          if (op == 3'd1) s = av + ((~bv) & mask) + 64'd1;
          else            s = av + bv;
          res = res | 36'((s & mask) << (k * w));
          cy[k] = s[w];
        end
      end
      default: res = '0;
    endcase
  endfunction

  task automatic run_op(input string req, input logic [35:0] a, input logic [35:0] b,
                        input logic [2:0] op, input logic [1:0] md);
    logic [35:0] er;
    logic [3:0]  ec;
    model(a, b, op, md, er, ec);
    @(negedge clk);
    aIn = a; bIn = b; opIn = op; laneMode = md; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check(req, {28'd0, result}, {28'd0, er});
    check(req, {60'd0, carryOut}, {60'd0, ec});
    check(req, {63'd0, validOut}, 64'd1);
  endtask

  task automatic test_reset();
    rstN = 1'b0; validIn = 1'b0; opIn = '0; laneMode = '0; aIn = '0; bIn = '0;
    repeat (3) @(negedge clk);
    check("R1", {28'd0, result}, 64'd0);
    check("R1", {60'd0, carryOut}, 64'd0);
    check("R1", {63'd0, validOut}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {28'd0, result}, 64'd0);
    check("R1", {63'd0, validOut}, 64'd0);
  endtask

  task automatic test_wide();
    run_op("R2", 36'hFFFFFFFFF, 36'h000000001, 3'd0, 2'b00);
    check("R2 hand", {28'd0, result}, 64'd0);
    check("R2 hand", {60'd0, carryOut}, 64'h1);
    run_op("R2", 36'h12345678A, 36'h0F0F0F0F0, 3'd0, 2'b00);
    run_op("R5", 36'hFFFFFFFFF, 36'h000000001, 3'd0, 2'b11);
    check("R5 hand", {60'd0, carryOut}, 64'h1);
  endtask

  task automatic test_half();
    run_op("R3", {18'h00001, 18'h3FFFF}, {18'h00000, 18'h00001}, 3'd0, 2'b01);
    check("R3 hand", {28'd0, result}, {28'd0, 18'h00001, 18'h00000});
    check("R3 hand", {60'd0, carryOut}, 64'h1);
    run_op("R3", {18'h3FFFF, 18'h3FFFF}, {18'h00001, 18'h00001}, 3'd0, 2'b01);
    check("R8 half", {60'd0, carryOut}, 64'h3);
  endtask

  task automatic test_quarter();
    run_op("R4", {9'h1FF, 9'h0FF, 9'h1FF, 9'h001}, {9'h001, 9'h001, 9'h001, 9'h1FF}, 3'd0, 2'b10);
    check("R4 hand", {28'd0, result}, {28'd0, 9'h000, 9'h100, 9'h000, 9'h000});
    check("R4 hand", {60'd0, carryOut}, 64'hB);
    run_op("R4", 36'h5A5A5A5A5, 36'hA5A5A5A5A, 3'd0, 2'b10);
  endtask

  task automatic test_sub();
    run_op("R6 wide", 36'h000000005, 36'h000000007, 3'd1, 2'b00);
    check("R6 borrow", {60'd0, carryOut}, 64'h0);
    run_op("R6 half", {18'h00005, 18'h00000}, {18'h00003, 18'h00001}, 3'd1, 2'b01);
    check("R6 hand", {28'd0, result}, {28'd0, 18'h00002, 18'h3FFFF});
    check("R6 hand", {60'd0, carryOut}, 64'h2);
    run_op("R6 quarter", {9'h000, 9'h010, 9'h100, 9'h003}, {9'h001, 9'h010, 9'h0FF, 9'h004}, 3'd1, 2'b10);
    check("R6 hand", {60'd0, carryOut}, 64'h6);
  endtask

  task automatic test_logic();
    for (int m = 0; m < 4; m++) begin
      run_op("R7 and", 36'hF0F0F0F0F, 36'hFF00FF00F, 3'd2, 2'(m));
      run_op("R7 or",  36'hF0F0F0F0F, 36'h0FF00FF00, 3'd3, 2'(m));
      run_op("R7 xor", 36'hFFFFFFFFF, 36'h123456789, 3'd4, 2'(m));
    end
    for (int o = 5; o < 8; o++) begin
      run_op("R7 undef", 36'hFFFFFFFFF, 36'hFFFFFFFFF, 3'(o), 2'b00);
      check("R7 undef", {28'd0, result}, 64'd0);
    end
  endtask

  task automatic test_hold();
    logic [35:0] keepRes;
    logic [3:0]  keepCy;
    run_op("R9", 36'hFFFFFFFFF, 36'h000000001, 3'd0, 2'b10);
    keepRes = result; keepCy = carryOut;
    @(negedge clk);
    aIn = 36'h111111111; bIn = 36'h222222222; opIn = 3'd4; laneMode = 2'b01; validIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 hold", {28'd0, result}, {28'd0, keepRes});
    check("R9 hold", {60'd0, carryOut}, {60'd0, keepCy});
    check("R9 strobe", {63'd0, validOut}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_wide();
    test_half();
    test_quarter();
    test_sub();
    test_logic();
    test_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule